// File: doc/BRIEF.md
# USB Micro-frame Index Counter

This block holds the running micro-frame counter of a high-speed USB host controller, together with an 11-bit start-of-frame number kept in a shadow register for the token generator. A one-cycle tick marks the end of each 125 µs micro-frame. While the controller is running, each tick advances the 14-bit counter by one. Bits 12:3 of the counter select one of 1024 periodic frame list entries, so each entry stays selected for eight micro-frames in a row.

The shadow start-of-frame number advances once per millisecond. This happens on the tick that moves the counter's low three bits from 000 to 001. Software reaches the counter through a 32-bit port. Reads return the counter with zeros above it. A full-word write that is made while the controller is halted loads the counter. The same write also copies counter bits 13:3 into the shadow, so the two values stay consistent. A write that is not allowed is dropped, and the block raises a one-cycle error flag.

Top module: `uframe_index_ctr`

## Requirements
- R1: `rd_data` bits 13:0 always equal the counter, and bits 31:14 always read zero.
- R2: After reset, the counter, the shadow start-of-frame number and `wr_err` are all zero.
- R3: The counter adds one on a clock where `uf_tick`=1, `run_en`=1 and `halted`=0. It goes from 0x3FFF to 0x0000. If any of these conditions is missing, it holds its value.
- R4: `list_idx` always equals counter bits 12:3.
- R5: The shadow adds one on a counter advance that starts from low bits 000. It goes from 0x7FF to 0x000. At any other time it holds.
- R6: A write is accepted when `wr_en`=1, `wr_be`=4'b1111, `halted`=1 and `run_en`=0. It loads `wr_data[13:0]` into the counter and `wr_data[13:3]` into the shadow. `wr_data[31:14]` is ignored.
- R7: A write made while `run_en`=1 or `halted`=0 changes nothing. `wr_err` is 1 on the next clock only.
- R8: A write with `wr_be` other than 4'b1111 changes nothing and sets `wr_err` on the next clock.
- R9: When a tick arrives in the same clock as an accepted write, the written value wins and the tick is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uf_tick | input | 1 | One-cycle end-of-micro-frame pulse |
| run_en | input | 1 | Controller run/stop state (1 = running) |
| halted | input | 1 | Controller halted status |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| wr_be | input | 4 | Byte enables of the write |
| rd_data | output | 32 | Register read value |
| frame_idx | output | 14 | Micro-frame counter |
| list_idx | output | 10 | Periodic frame list entry index |
| sof_num | output | 11 | Shadow start-of-frame number |
| wr_err | output | 1 | One-cycle pulse for a rejected write |

## Verification
A micro-frame tick and a register write can arrive in the same clock. The same is true of a counter wrap and a shadow wrap. The vector table drives a tick together with an accepted write, and it expects the written value with no increment. It also drives ticks together with rejected writes while the controller runs, and it expects an error pulse and unchanged state. A loaded value of 0x3FFE is then ticked through 0x3FFF, 0x0000 and 0x0001. At that point the shadow must stay at 0x7FF across the counter wrap and only then roll over to zero.

// File: rtl/uframe_pkg.sv
package uframe_pkg;

   typedef enum logic [1:0] {
      WR_IDLE   = 2'd0,
      WR_TAKE   = 2'd1,
      WR_REJECT = 2'd2
   } wr_verdict_e;

   function automatic wr_verdict_e judge_write(input logic strobe,
                                               input logic be_ok,
                                               input logic run_on,
                                               input logic is_halted);
      if (!strobe)
         return WR_IDLE;
      else if (be_ok && is_halted && !run_on)
         return WR_TAKE;
      else
         return WR_REJECT;
   endfunction

endpackage

// File: rtl/uframe_wr_gate.sv
module uframe_wr_gate
   import uframe_pkg::*;
#(
   parameter int BE_W          = 4,
   parameter bit NEED_FULL_WORD = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [BE_W-1:0] wr_be,
   input  logic            run_en,
   input  logic            halted,
   output logic            take,
   output logic            err_q
);

   logic        be_ok;
   wr_verdict_e verdict;

   generate
      if (NEED_FULL_WORD) begin : g_full_word
         assign be_ok = &wr_be;
      end else begin : g_any_width
         assign be_ok = 1'b1;
      end
   endgenerate

   always_comb begin
      verdict = judge_write(wr_en, be_ok, run_en, halted);
      take    = (verdict == WR_TAKE);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         err_q <= 1'b0;
      else
         err_q <= (verdict == WR_REJECT);
   end

endmodule

// File: rtl/uframe_counter.sv
module uframe_counter #(
   parameter int IDX_W = 14,
   parameter int SUB_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IDX_W-1:0] load_val,
   input  logic             step,
   output logic [IDX_W-1:0] cnt,
   output logic             sub_start
);

   localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (step)
         cnt <= cnt + ONE;
   end

   // advance that takes the sub-frame bits from all-zero to one
   assign sub_start = step && !load && (cnt[SUB_W-1:0] == '0);

endmodule

// File: rtl/uframe_sof_shadow.sv
module uframe_sof_shadow #(
   parameter int SOF_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [SOF_W-1:0] load_val,
   input  logic             adv,
   output logic [SOF_W-1:0] sof
);

   localparam logic [SOF_W-1:0] ONE = SOF_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)
         sof <= '0;
      else if (load)
         sof <= load_val;
      else if (adv)
         sof <= sof + ONE;
   end

endmodule

// File: rtl/uframe_index_ctr.sv
module uframe_index_ctr #(
   parameter int REG_W      = 32,
   parameter int IDX_W      = 14,
   parameter int SUB_W      = 3,
   parameter int LIST_W     = 10,
   parameter int SOF_W      = 11,
   parameter bit FULL_WORD  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              uf_tick,
   input  logic              run_en,
   input  logic              halted,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wr_data,
   input  logic [REG_W/8-1:0] wr_be,
   output logic [REG_W-1:0]  rd_data,
   output logic [IDX_W-1:0]  frame_idx,
   output logic [LIST_W-1:0] list_idx,
   output logic [SOF_W-1:0]  sof_num,
   output logic              wr_err
);

   localparam int BE_W  = REG_W / 8;
   localparam int HI_W  = IDX_W - SUB_W;
   localparam int PAD_W = REG_W - IDX_W;

   generate
      if (REG_W % 8 != 0) begin : g_bad_reg_w
         $error("REG_W must be a whole number of bytes");
      end
      if (IDX_W >= REG_W) begin : g_bad_idx_w
         $error("IDX_W must be narrower than REG_W");
      end
      if (SOF_W != HI_W) begin : g_bad_sof_w
         $error("SOF_W must equal IDX_W - SUB_W");
      end
      if (LIST_W > HI_W) begin : g_bad_list_w
         $error("LIST_W cannot exceed IDX_W - SUB_W");
      end
   endgenerate

   logic take;
   logic step;
   logic sub_start;

   uframe_wr_gate #(
      .BE_W           (BE_W),
      .NEED_FULL_WORD (FULL_WORD)
   ) u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_be  (wr_be),
      .run_en (run_en),
      .halted (halted),
      .take   (take),
      .err_q  (wr_err)
   );

   assign step = uf_tick && run_en && !halted;

   uframe_counter #(
      .IDX_W (IDX_W),
      .SUB_W (SUB_W)
   ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (take),
      .load_val  (wr_data[IDX_W-1:0]),
      .step      (step),
      .cnt       (frame_idx),
      .sub_start (sub_start)
   );

   uframe_sof_shadow #(
      .SOF_W (SOF_W)
   ) u_sof (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (take),
      .load_val (wr_data[IDX_W-1:SUB_W]),
      .adv      (sub_start),
      .sof      (sof_num)
   );

   assign list_idx = frame_idx[SUB_W+LIST_W-1:SUB_W];
   assign rd_data  = {{PAD_W{1'b0}}, frame_idx};

endmodule

// File: rtl/uframe_index_ctr_chk.sv
module uframe_index_ctr_chk #(
   parameter int REG_W  = 32,
   parameter int IDX_W  = 14,
   parameter int SUB_W  = 3,
   parameter int SOF_W  = 11
) (
   input logic               clk,
   input logic               rst_n,
   input logic               uf_tick,
   input logic               run_en,
   input logic               halted,
   input logic               wr_en,
   input logic [REG_W-1:0]   wr_data,
   input logic [REG_W/8-1:0] wr_be,
   input logic [REG_W-1:0]   rd_data,
   input logic [IDX_W-1:0]   frame_idx,
   input logic [SOF_W-1:0]   sof_num,
   input logic               wr_err
);

   logic ok_wr, bad_wr, adv;
   assign ok_wr  = wr_en && (&wr_be) && halted && !run_en;
   assign bad_wr = wr_en && !ok_wr;
   assign adv    = uf_tick && run_en && !halted && !ok_wr;

   p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[REG_W-1:IDX_W] == '0);

   p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(adv) |-> frame_idx == IDX_W'($past(frame_idx) + 1'b1));

   p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && !$past(adv) && !$past(ok_wr) |-> $stable(frame_idx));

   p_sof_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(adv) && ($past(frame_idx[SUB_W-1:0]) == '0)
      |-> sof_num == SOF_W'($past(sof_num) + 1'b1));

   p_load_through_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(ok_wr)
      |-> frame_idx == $past(wr_data[IDX_W-1:0]) && sof_num == $past(wr_data[IDX_W-1:SUB_W]));

   p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> wr_err == $past(bad_wr));

endmodule

bind uframe_index_ctr uframe_index_ctr_chk #(
   .REG_W (REG_W),
   .IDX_W (IDX_W),
   .SUB_W (SUB_W),
   .SOF_W (SOF_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .uf_tick   (uf_tick),
   .run_en    (run_en),
   .halted    (halted),
   .wr_en     (wr_en),
   .wr_data   (wr_data),
   .wr_be     (wr_be),
   .rd_data   (rd_data),
   .frame_idx (frame_idx),
   .sof_num   (sof_num),
   .wr_err    (wr_err)
);

// File: tb/uframe_index_ctr_tb_top.sv
module uframe_index_ctr_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        uf_tick = 1'b0;
   logic        run_en = 1'b0;
   logic        halted = 1'b1;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [3:0]  wr_be = '0;
   logic [31:0] rd_data;
   logic [13:0] frame_idx;
   logic [9:0]  list_idx;
   logic [10:0] sof_num;
   logic        wr_err;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   uframe_index_ctr dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .uf_tick   (uf_tick),
      .run_en    (run_en),
      .halted    (halted),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .wr_be     (wr_be),
      .rd_data   (rd_data),
      .frame_idx (frame_idx),
      .list_idx  (list_idx),
      .sof_num   (sof_num),
      .wr_err    (wr_err)
   );

   // {wr, data32, be4, run, halt, tick, exp_idx14, exp_sof11, exp_err}
   localparam int NV = 16;
   localparam logic [65:0] VEC [NV] = '{
      {1'b1, 32'h0000_0012, 4'hF, 1'b0, 1'b1, 1'b0, 14'h0012, 11'h002, 1'b0}, // R6
      {1'b1, 32'hFFFF_C00D, 4'hF, 1'b0, 1'b1, 1'b0, 14'h000D, 11'h001, 1'b0}, // R6 upper ignored
      {1'b0, 32'h0,         4'h0, 1'b1, 1'b0, 1'b1, 14'h000E, 11'h001, 1'b0}, // R3
      {1'b0, 32'h0,         4'h0, 1'b1, 1'b0, 1'b1, 14'h000F, 11'h001, 1'b0}, // R3
      {1'b0, 32'h0,         4'h0, 1'b1, 1'b0, 1'b1, 14'h0010, 11'h001, 1'b0}, // R5 no adv on 111->000
      {1'b0, 32'h0,         4'h0, 1'b1, 1'b0, 1'b1, 14'h0011, 11'h002, 1'b0}, // R5 000->001
      {1'b0, 32'h0,         4'h0, 1'b1, 1'b0, 1'b0, 14'h0011, 11'h002, 1'b0}, // R3 hold
      {1'b1, 32'h0000_0005, 4'hF, 1'b1, 1'b0, 1'b1, 14'h0012, 11'h002, 1'b1}, // R7 write while running
      {1'b1, 32'h0000_0005, 4'hF, 1'b0, 1'b0, 1'b0, 14'h0012, 11'h002, 1'b1}, // R7 not halted
      {1'b0, 32'h0,         4'h0, 1'b0, 1'b1, 1'b1, 14'h0012, 11'h002, 1'b0}, // R3 gated tick, R7 pulse ends
      {1'b1, 32'h0000_0105, 4'h7, 1'b0, 1'b1, 1'b0, 14'h0012, 11'h002, 1'b1}, // R8
      {1'b1, 32'h0000_3FFE, 4'hF, 1'b0, 1'b1, 1'b1, 14'h3FFE, 11'h7FF, 1'b0}, // R9
      {1'b0, 32'h0,         4'h0, 1'b1, 1'b0, 1'b1, 14'h3FFF, 11'h7FF, 1'b0}, // R3
      {1'b0, 32'h0,         4'h0, 1'b1, 1'b0, 1'b1, 14'h0000, 11'h7FF, 1'b0}, // R3 wrap
      {1'b0, 32'h0,         4'h0, 1'b1, 1'b0, 1'b1, 14'h0001, 11'h000, 1'b0}, // R5 wrap
      {1'b0, 32'h0,         4'h0, 1'b1, 1'b0, 1'b1, 14'h0002, 11'h000, 1'b0}  // R4
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic check_state(input logic [13:0] ei, input logic [10:0] es, input logic ee);
      chk("R3 frame_idx", 32'(frame_idx), 32'(ei));
      chk("R5 sof_num", 32'(sof_num), 32'(es));
      chk("R7 wr_err", 32'(wr_err), 32'(ee));
      chk("R1 rd_data", rd_data, {18'b0, ei});
      chk("R4 list_idx", 32'(list_idx), 32'(ei[12:3]));
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R2: reset state
      check_state(14'h0, 11'h0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check_state(14'h0, 11'h0, 1'b0);

      for (int i = 0; i < NV; i++) begin
         {wr_en, wr_data, wr_be, run_en, halted, uf_tick} = VEC[i][65:26];
         @(negedge clk);
         wr_en = 1'b0;
         uf_tick = 1'b0;
         check_state(VEC[i][25:12], VEC[i][11:1], VEC[i][0]);
      end

      // R2: reset mid-run returns both counters to zero together
      run_en = 1'b1; halted = 1'b0; uf_tick = 1'b1;
      rst_n = 1'b0;
      @(negedge clk);
      uf_tick = 1'b0;
      chk("R2 idx after reset", 32'(frame_idx), 32'h0);
      chk("R2 sof after reset", 32'(sof_num), 32'h0);
      rst_n = 1'b1;

      // R5: full 8-tick period from zero gives exactly one shadow step
      for (int k = 0; k < 8; k++) begin
         uf_tick = 1'b1;
         @(negedge clk);
         uf_tick = 1'b0;
      end
      chk("R5 idx after 8 ticks", 32'(frame_idx), 32'h8);
      chk("R5 sof after 8 ticks", 32'(sof_num), 32'h1);
      chk("R4 list after 8 ticks", 32'(list_idx), 32'h1);

      // R8: 16-bit write rejected while halted
      run_en = 1'b0; halted = 1'b1;
      wr_en = 1'b1; wr_data = 32'h0000_2222; wr_be = 4'b0011;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R8 idx unchanged", 32'(frame_idx), 32'h8);
      chk("R8 err", 32'(wr_err), 32'h1);
      @(negedge clk);
      chk("R7 err one cycle", 32'(wr_err), 32'h0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule